// File: doc/BRIEF.md
# Hashed Page Table Entry Formatter

This block turns one translation request into the two 64-bit words of a hashed page table entry, and also gives the primary hash and the base index of the entry group that hash selects. A request carries a virtual address, a physical address and a page-size index. The page-size index selects one line of a small configuration table. Each line holds the page shift, a large-page size code and a mask of AVPN bits to drop. Software loads the table through a write port.

Requests enter through a valid/ready handshake. Results are registered and appear one cycle later with a valid flag. An equality comparator checks the registered first word against a probe word over the AVPN field only. A page-size index that is unsupported or out of range gives an error result with all data outputs zero.

Top module: `hpte_formatter`

## Requirements
- R1: `in_ready` is high whenever reset is released. A request accepted on a clock edge (in_valid high) raises `out_valid` after exactly that edge. An edge with in_valid low leaves `out_valid` low after it.
- R2: For a supported size, first-word bits 63..7 equal (VA >> 23) with the bits of that size's configured AVPN mask cleared. Bits 6..3, 1 and 0 are zero.
- R3: First-word bit 2 (the large-page flag) is 1 for every supported page-size index other than 0 and is 0 for index 0.
- R4: For index 0 the second word is PA AND 0x3FFF_FFFF_FFFF_F000.
- R5: For every other supported index the second word is PA with its low `shift` bits cleared, ORed with the configured size code shifted left by 12.
- R6: The 39-bit hash is (VA >> 28) XOR (VA[27:0] >> shift), where shift is the configured shift of the requested index.
- R7: The group base is (hash AND hash_mask) << 3, because each group holds 8 entries.
- R8: `out_match` is 1 exactly when ((out_vword XOR probe_v) AND 0xFFFF_FFFF_FFFF_FF80) is zero.
- R9: The size indices are 0=4K, 1=64K, 2=64K inside a 4K segment, 3=1M, 4=16M and 5=16G. An index above 5, or one whose configured shift is 0, completes with `out_err` high and with both words, the hash and the group all zero.
- R10: After reset every table line is zero except that line 0 has shift 12. A write to an index of 6 or more changes nothing.
- R11: A table write takes effect for requests accepted on later edges. A request accepted on the same edge as the write uses the old line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | 3 | Table line to write |
| cfg_shift | input | 6 | Page shift to store (0 = unsupported) |
| cfg_code | input | 8 | Large-page size code to store |
| cfg_avpn_mask | input | 41 | AVPN bits to clear, aligned to VA >> 23 |
| hash_mask | input | 39 | Mask applied to the hash before the group index |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_va | input | 64 | Virtual address |
| in_pa | input | 64 | Physical address, aligned to the page size |
| in_psize | input | 3 | Page-size index |
| probe_v | input | 64 | First word to compare against the result |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Unsupported page size |
| out_vword | output | 64 | First entry word |
| out_rword | output | 64 | Second entry word |
| out_hash | output | 39 | Primary hash |
| out_group | output | 42 | Base entry index of the group |
| out_match | output | 1 | AVPN field of out_vword equals that of probe_v |

## Verification
The bench targets the places where the shift from the table reaches two variable shifters. It uses a 64K size whose mask clears one AVPN bit, a 1M size with a non-zero code, and a 16M size with a zero code. A design that used the wrong shift, or applied the RPN mask to large pages, would give the wrong second word or the wrong hash here. Index 2 (shift 0), index 5, index 7 and a write to index 6 must all give zeroed error results; a design that decoded only the index range would pass bad entries through. A table write made on the same edge as a request must not affect that request; a bypassed read would use the new shift one cycle early. Probes that differ only below bit 7 and probes that differ at bit 7 show a comparator with a misplaced mask.

// File: rtl/hpte_pkg.sv
// Package: fixed field positions of the hashed page table entry words.
// Assumes 64-bit entry words; these positions are format constants.
package hpte_pkg;
    localparam int WORD_W      = 64;
    localparam int HASH_W      = 39;
    localparam int AVPN_LSB    = 7;
    localparam int VA_AVPN_LSB = 23;
    localparam int VA_SEG_LSB  = 28;
    localparam int LARGE_BIT   = 2;
    localparam int CODE_LSB    = 12;
    localparam int GROUP_LOG2  = 3;
    localparam logic [WORD_W-1:0] RPN_MASK  = 64'h3FFF_FFFF_FFFF_F000;
    localparam logic [WORD_W-1:0] AVPN_MASK = 64'hFFFF_FFFF_FFFF_FF80;
endpackage

// File: rtl/hpte_cfg_table.sv
// Per-page-size configuration table: shift, size code and AVPN mask.
// Line 0 resets to shift 12, all other lines to zero. Writes to lines
// at or above NUM_SIZES are dropped. The read port is combinational, so
// a write becomes visible on the following cycle.
module hpte_cfg_table #(
    parameter int NUM_SIZES = 6,
    parameter int IDX_W     = 3,
    parameter int SHIFT_W   = 6,
    parameter int CODE_W    = 8,
    parameter int MASK_W    = 41,
    parameter int RST_SHIFT0 = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [SHIFT_W-1:0] wr_shift,
    input  logic [CODE_W-1:0]  wr_code,
    input  logic [MASK_W-1:0]  wr_mask,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [SHIFT_W-1:0] rd_shift,
    output logic [CODE_W-1:0]  rd_code,
    output logic [MASK_W-1:0]  rd_mask,
    output logic               rd_ok
);
    logic [SHIFT_W-1:0] shift_q [NUM_SIZES];
    logic [CODE_W-1:0]  code_q  [NUM_SIZES];
    logic [MASK_W-1:0]  mask_q  [NUM_SIZES];

    for (genvar i = 0; i < NUM_SIZES; i++) begin : g_line
        // Hold one table line; load it when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shift_q[i] <= (i == 0) ? SHIFT_W'(RST_SHIFT0) : '0;
                code_q[i]  <= '0;
                mask_q[i]  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                shift_q[i] <= wr_shift;
                code_q[i]  <= wr_code;
                mask_q[i]  <= wr_mask;
            end
        end

        // R11: a write lands in the addressed line on the next cycle
        p_line_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(i)) |=>
                (shift_q[i] == $past(wr_shift) && code_q[i] == $past(wr_code)
                 && mask_q[i] == $past(wr_mask)));
    end

    // Select the addressed line; out-of-range or zero-shift lines are not ok.
    always_comb begin
        rd_shift = '0;
        rd_code  = '0;
        rd_mask  = '0;
        rd_ok    = 1'b0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_shift = shift_q[i];
                rd_code  = code_q[i];
                rd_mask  = mask_q[i];
                rd_ok    = (shift_q[i] != '0);
            end
        end
    end
endmodule

// File: rtl/hpte_word_build.sv
// Builds the two entry words from the addresses and one table line.
// Assumes the physical address is already aligned to the page size.
// Pure combinational logic.
module hpte_word_build
    import hpte_pkg::*;
#(
    parameter int PA_W    = 64,
    parameter int SHIFT_W = 6,
    parameter int CODE_W  = 8,
    parameter int MASK_W  = 41
) (
    input  logic [MASK_W-1:0]  va_hi,
    input  logic [PA_W-1:0]    pa,
    input  logic               small_page,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [CODE_W-1:0]  code,
    input  logic [MASK_W-1:0]  avpn_mask,
    output logic [WORD_W-1:0]  vword,
    output logic [WORD_W-1:0]  rword
);
    logic [MASK_W-1:0] avpn;
    logic [WORD_W-1:0] pa_w;
    logic [WORD_W-1:0] low_bits;

    // Form the first word: masked AVPN plus the large-page flag.
    always_comb begin
        avpn  = va_hi & ~avpn_mask;
        vword = WORD_W'({avpn, {AVPN_LSB{1'b0}}});
        vword[LARGE_BIT] = ~small_page;
    end

    // Form the second word: RPN mask for small pages, else clear and insert code.
    always_comb begin
        pa_w     = WORD_W'(pa);
        low_bits = (WORD_W'(1) << shift) - WORD_W'(1);
        if (small_page)
            rword = pa_w & RPN_MASK;
        else
            rword = (pa_w & ~low_bits) | (WORD_W'(code) << CODE_LSB);
    end
endmodule

// File: rtl/hpte_hash.sv
// Primary hash for 256MB segments and the group base index it selects.
// Pure combinational logic.
module hpte_hash
    import hpte_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int SHIFT_W = 6,
    localparam int GRP_W  = HASH_W + GROUP_LOG2
) (
    input  logic [VA_W-1:0]    va,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [HASH_W-1:0]  hmask,
    output logic [HASH_W-1:0]  hash,
    output logic [GRP_W-1:0]   group
);
    logic [VA_SEG_LSB-1:0] offs;

    // Fold segment bits against the shifted in-segment offset.
    always_comb begin
        offs  = va[VA_SEG_LSB-1:0] >> shift;
        hash  = HASH_W'(va[VA_W-1:VA_SEG_LSB]) ^ HASH_W'(offs);
        group = {hash & hmask, {GROUP_LOG2{1'b0}}};
    end
endmodule

// File: rtl/hpte_formatter.sv
// Top: accepts one request per cycle and registers the entry words,
// hash, group base and error flag. The comparator works on the
// registered first word. Results are not held back: the consumer must
// take each one in the cycle out_valid is high.
module hpte_formatter
    import hpte_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 64,
    parameter int NUM_SIZES = 6,
    parameter int SHIFT_W   = 6,
    parameter int CODE_W    = 8,
    localparam int IDX_W    = 3,
    localparam int MASK_W   = VA_W - VA_AVPN_LSB,
    localparam int GRP_W    = HASH_W + GROUP_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [CODE_W-1:0]  cfg_code,
    input  logic [MASK_W-1:0]  cfg_avpn_mask,
    input  logic [HASH_W-1:0]  hash_mask,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [VA_W-1:0]    in_va,
    input  logic [PA_W-1:0]    in_pa,
    input  logic [IDX_W-1:0]   in_psize,
    input  logic [WORD_W-1:0]  probe_v,
    output logic               out_valid,
    output logic               out_err,
    output logic [WORD_W-1:0]  out_vword,
    output logic [WORD_W-1:0]  out_rword,
    output logic [HASH_W-1:0]  out_hash,
    output logic [GRP_W-1:0]   out_group,
    output logic               out_match
);
    logic [SHIFT_W-1:0] line_shift;
    logic [CODE_W-1:0]  line_code;
    logic [MASK_W-1:0]  line_mask;
    logic               line_ok;
    logic [WORD_W-1:0]  vword_d, rword_d;
    logic [HASH_W-1:0]  hash_d;
    logic [GRP_W-1:0]   group_d;

    assign in_ready = 1'b1;

    hpte_cfg_table #(
        .NUM_SIZES(NUM_SIZES), .IDX_W(IDX_W), .SHIFT_W(SHIFT_W),
        .CODE_W(CODE_W), .MASK_W(MASK_W), .RST_SHIFT0(12)
    ) i_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_shift(cfg_shift),
        .wr_code(cfg_code), .wr_mask(cfg_avpn_mask),
        .rd_idx(in_psize), .rd_shift(line_shift), .rd_code(line_code),
        .rd_mask(line_mask), .rd_ok(line_ok)
    );

    hpte_word_build #(
        .PA_W(PA_W), .SHIFT_W(SHIFT_W), .CODE_W(CODE_W), .MASK_W(MASK_W)
    ) i_words (
        .va_hi(in_va[VA_W-1:VA_AVPN_LSB]), .pa(in_pa),
        .small_page(in_psize == '0), .shift(line_shift), .code(line_code),
        .avpn_mask(line_mask), .vword(vword_d), .rword(rword_d)
    );

    hpte_hash #(.VA_W(VA_W), .SHIFT_W(SHIFT_W)) i_hash (
        .va(in_va), .shift(line_shift), .hmask(hash_mask),
        .hash(hash_d), .group(group_d)
    );

    // Register the result of each accepted request; unsupported sizes give zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_vword <= '0;
            out_rword <= '0;
            out_hash  <= '0;
            out_group <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_err   <= ~line_ok;
                out_vword <= line_ok ? vword_d : '0;
                out_rword <= line_ok ? rword_d : '0;
                out_hash  <= line_ok ? hash_d  : '0;
                out_group <= line_ok ? group_d : '0;
            end
        end
    end

    // Compare AVPN fields of the registered first word and the probe.
    assign out_match = ((out_vword ^ probe_v) & AVPN_MASK) == '0;

    // R1: one result per accepted request, one cycle later
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9: error results carry no entry data
    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_vword == '0 && out_rword == '0
                                    && out_hash == '0 && out_group == '0));
    // R9: indices beyond the table always fail
    p_oob_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_psize >= IDX_W'(NUM_SIZES)) |=> out_err);
    // R3: large flag follows the requested index
    p_large_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && line_ok) |=> (out_vword[LARGE_BIT] == ($past(in_psize) != '0)));
    // R4: small pages keep only the real page number field
    p_small_rpn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && line_ok && in_psize == '0) |=>
            (out_rword == (WORD_W'($past(in_pa)) & RPN_MASK)));
    // R7: group index is always aligned to a group of 8
    p_group_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_group[GROUP_LOG2-1:0] == '0));
endmodule

// File: tb/test_hpte_formatter.sv
module test_hpte_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [5:0]  cfg_shift = '0;
    logic [7:0]  cfg_code = '0;
    logic [40:0] cfg_avpn_mask = '0;
    logic [38:0] hash_mask = 39'h00_0000_FFFF;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_va = '0, in_pa = '0, probe_v = '0;
    logic [2:0]  in_psize = '0;
    logic        out_valid, out_err, out_match;
    logic [63:0] out_vword, out_rword;
    logic [38:0] out_hash;
    logic [41:0] out_group;

    int tests = 0;
    int fails = 0;

    // Bench-side copy of what the table should hold
    logic [5:0]  sh [8];
    logic [7:0]  cd [8];
    logic [40:0] mk [8];

    hpte_formatter i_hpte_formatter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_shift(cfg_shift), .cfg_code(cfg_code), .cfg_avpn_mask(cfg_avpn_mask),
        .hash_mask(hash_mask), .in_valid(in_valid), .in_ready(in_ready),
        .in_va(in_va), .in_pa(in_pa), .in_psize(in_psize), .probe_v(probe_v),
        .out_valid(out_valid), .out_err(out_err), .out_vword(out_vword),
        .out_rword(out_rword), .out_hash(out_hash), .out_group(out_group),
        .out_match(out_match)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [63:0] va;
        logic [63:0] pa;
        logic [2:0]  ps;
        logic        err;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{64'h0123_4567_89AB_CDEF, 64'h0000_0012_3456_7ABC, 3'd0, 1'b0},
        '{64'hC000_0000_1234_5678, 64'h0000_0000_ABCD_0000, 3'd1, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_00FF_FFF0_0000, 3'd3, 1'b0},
        '{64'h0000_0A5A_5F0F_0F0F, 64'h0000_0001_0100_0000, 3'd4, 1'b0},
        '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_1000, 3'd2, 1'b1},
        '{64'h7777_0000_0000_0000, 64'h0000_0000_0000_0000, 3'd5, 1'b1},
        '{64'h8000_0000_F000_0000, 64'h3FFF_FFFF_FFFF_FFFF, 3'd0, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd7, 1'b1}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [5:0] s,
                             input logic [7:0] c, input logic [40:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_shift = s; cfg_code = c; cfg_avpn_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 3'd6) begin sh[idx] = s; cd[idx] = c; mk[idx] = m; end
    endtask

    // Independent model of one result
    task automatic model(input logic [63:0] va, input logic [63:0] pa, input logic [2:0] ps,
                         output logic e, output logic [63:0] v, output logic [63:0] r,
                         output logic [38:0] h, output logic [41:0] g);
        logic [63:0] lm;
        e = (ps > 3'd5) || (sh[ps] == 6'd0);
        if (e) begin v = '0; r = '0; h = '0; g = '0; end
        else begin
            v  = (((va >> 23) & ~{23'd0, mk[ps]}) << 7) | ((ps != 0) ? 64'h4 : 64'h0);
            lm = (64'd1 << sh[ps]) - 64'd1;
            r  = (ps == 0) ? (pa & 64'h3FFF_FFFF_FFFF_F000)
                           : ((pa & ~lm) | ({56'd0, cd[ps]} << 12));
            h  = 39'(va >> 28) ^ 39'((va & 64'h0FFF_FFFF) >> sh[ps]);
            g  = {h & hash_mask, 3'b000};
        end
    endtask

    task automatic request(input logic [63:0] va, input logic [63:0] pa, input logic [2:0] ps);
        @(negedge clk);
        in_valid = 1'b1; in_va = va; in_pa = pa; in_psize = ps;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_result(input logic [63:0] va, input logic [63:0] pa,
                                input logic [2:0] ps, input string tag);
        logic e; logic [63:0] v, r; logic [38:0] h; logic [41:0] g;
        model(va, pa, ps, e, v, r, h, g);
        check(out_valid === 1'b1, {tag, " R1 valid"}, 64'(out_valid), 64'd1);
        check(out_err === e, {tag, " R9 err"}, 64'(out_err), 64'(e));
        check(out_vword === v, {tag, " R2/R3 vword"}, out_vword, v);
        check(out_rword === r, {tag, " R4/R5 rword"}, out_rword, r);
        check(out_hash === h, {tag, " R6 hash"}, 64'(out_hash), 64'(h));
        check(out_group === g, {tag, " R7 group"}, 64'(out_group), 64'(g));
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin sh[i] = '0; cd[i] = '0; mk[i] = '0; end
        sh[0] = 6'd12;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R10: reset state
        check(out_valid === 1'b0, "R1 reset valid", 64'(out_valid), 64'd0);
        check(in_ready === 1'b1, "R1 ready", 64'(in_ready), 64'd1);
        // R10: line 0 is 4K with shift 12 straight out of reset
        request(64'h0000_1234_5678_9ABC, 64'h0000_0000_8765_4321, 3'd0);
        check_result(64'h0000_1234_5678_9ABC, 64'h0000_0000_8765_4321, 3'd0, "R10 reset line0");
        @(negedge clk);
        check(out_valid === 1'b0, "R1 idle", 64'(out_valid), 64'd0);
        // R10: index 1 is unsupported right after reset
        request(64'h1, 64'h0, 3'd1);
        check(out_err === 1'b1, "R10 line1 zero after reset", 64'(out_err), 64'd1);

        cfg_write(3'd1, 6'd16, 8'h01, 41'h1);
        cfg_write(3'd3, 6'd20, 8'h38, 41'h0);
        cfg_write(3'd4, 6'd24, 8'h00, 41'h3);
        // R10: writes to index 6 are dropped, so index 6 still fails
        cfg_write(3'd6, 6'd16, 8'hFF, 41'h0);

        for (int k = 0; k < 8; k++) begin
            request(VECS[k].va, VECS[k].pa, VECS[k].ps);
            check_result(VECS[k].va, VECS[k].pa, VECS[k].ps, $sformatf("vec%0d", k));
            check(out_err === VECS[k].err, "R9 table err", 64'(out_err), 64'(VECS[k].err));
        end

        request(64'h5, 64'h5, 3'd6);
        check(out_err === 1'b1 && out_vword === '0, "R10 idx6 write ignored R9",
              64'(out_err), 64'd1);

        // R7: full hash mask
        hash_mask = '1;
        request(64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0123_0000, 3'd1);
        check_result(64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0123_0000, 3'd1, "R7 full mask");

        // R8: probe differs only below bit 7, then at bit 7
        probe_v = out_vword ^ 64'h7F;
        #1;
        check(out_match === 1'b1, "R8 low bits ignored", 64'(out_match), 64'd1);
        probe_v = out_vword ^ 64'h80;
        #1;
        check(out_match === 1'b0, "R8 bit 7 compared", 64'(out_match), 64'd0);
        probe_v = out_vword ^ 64'h8000_0000_0000_0000;
        #1;
        check(out_match === 1'b0, "R8 bit 63 compared", 64'(out_match), 64'd0);

        // R11: a write on the same edge as a request is not seen by it
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd1; cfg_shift = 6'd20; cfg_code = 8'h22; cfg_avpn_mask = '0;
        in_valid = 1'b1; in_va = 64'h0000_0000_0FFF_FFFF; in_pa = 64'h0000_0000_0FF0_0000;
        in_psize = 3'd1;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        check_result(64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0FF0_0000, 3'd1, "R11 old line");
        sh[1] = 6'd20; cd[1] = 8'h22; mk[1] = '0;
        request(64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0FF0_0000, 3'd1);
        check_result(64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0FF0_0000, 3'd1, "R11 new line");

        // R9: setting a shift to 0 disables the size
        cfg_write(3'd3, 6'd0, 8'h38, 41'h0);
        request(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_00FF_FFF0_0000, 3'd3);
        check(out_err === 1'b1 && out_rword === '0, "R9 shift zero", out_rword, 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule